// File: doc/BRIEF.md
# Landing-Pad Expectation Tracker

This block keeps the forward-edge control-flow state of one hart: a single bit that says whether the next retired instruction must be a landing pad. A qualifying indirect jump arms the bit. A landing pad whose label matches disarms it. A landing pad whose label does not match produces a one-cycle fault pulse instead. Whether any of this is active depends on an enable bit, and the hart's current privilege picks which configuration bit supplies that enable.

Traps and trap returns move the bit around. A trap parks the live bit in a machine or supervisor saved copy, picked by the privilege the trap enters, and then clears the live bit. MRET or SRET brings the saved copy back, or clears the live bit if the privilege being returned to has the feature disabled. The saved copy is cleared either way. The block only watches retire-time strobes. Decode, the register file and trap vectoring are done elsewhere.

Top module: `lp_track`

## Requirements
- R1: After reset, `lp_expect`, `lp_prev_m`, `lp_prev_s` and `lp_fault` are all 0. The value 1 means a landing pad is expected and 0 means none is.
- R2: Privileges are encoded as 2'b11 machine, 2'b01 supervisor and 2'b00 user (2'b10 is handled as user). The enable is `cfg_m_sec_en` in machine mode and `cfg_m_env_en` in supervisor mode. In user mode it is `cfg_s_env_en` when `HAS_SMODE` is 1 and `cfg_m_env_en` otherwise. With `HAS_EXT` = 0 the enable is always 0.
- R3: A retired indirect jump sets `lp_expect` on the next edge only when the current enable is 1 and `jump_src` is not 1, 5 or 7.
- R4: A landing pad retired with the enable at 1 and `lp_expect` at 1 faults when its label is nonzero and differs from `x7_hi`. In that case `lp_fault` is 1 for exactly the cycle after the edge, and `lp_expect` stays 1.
- R5: A landing pad retired with the enable at 1 and `lp_expect` at 1 clears `lp_expect` when its label is 0 or equals `x7_hi`.
- R6: A landing pad retired with the enable at 0, or with `lp_expect` at 0, changes no output and raises no fault.
- R7: A trap copies `lp_expect` into `lp_prev_m` when `trap_priv` is machine, and into `lp_prev_s` otherwise. It then clears `lp_expect`.
- R8: MRET loads `lp_expect` from `lp_prev_m` if the enable of `ret_priv` is 1, and clears `lp_expect` otherwise. It clears `lp_prev_m` in both cases.
- R9: SRET does the same as R8, but with `lp_prev_s`.
- R10: When several strobes are raised in one cycle, a trap wins over all of them and drops their updates and any fault. Among the others the order is MRET, then SRET, then landing pad, then jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_priv | input | 2 | Current privilege |
| ret_priv | input | 2 | Privilege targeted by MRET/SRET |
| cfg_m_sec_en | input | 1 | Machine-mode enable bit |
| cfg_m_env_en | input | 1 | Enable for supervisor (and user without S-mode) |
| cfg_s_env_en | input | 1 | Enable for user mode with S-mode |
| ev_jump | input | 1 | Indirect jump retired |
| jump_src | input | 5 | Source register index of the jump |
| ev_pad | input | 1 | Landing pad retired |
| pad_label | input | 20 | Label field of the landing pad |
| x7_hi | input | 20 | Bits 31:12 of register x7 |
| ev_trap | input | 1 | Trap taken |
| trap_priv | input | 2 | Privilege the trap enters |
| ev_mret | input | 1 | MRET retired |
| ev_sret | input | 1 | SRET retired |
| lp_expect | output | 1 | Landing pad expected |
| lp_prev_m | output | 1 | Machine saved copy |
| lp_prev_s | output | 1 | Supervisor saved copy |
| lp_fault | output | 1 | Landing-pad fault pulse |

## Verification
Every output is a register, so each result is due on the first clock edge after the cycle that holds the strobe. That includes the state bits, the saved copies and the fault pulse. The bench drives a stimulus on the falling edge and lets one rising edge pass. It compares all four outputs on the next falling edge against a reference model that it updated at that same rising edge, and then clears the strobes, so each stimulus is judged exactly one edge later. The same-cycle conflicts of R10 are covered both by directed steps and by random cycles that raise several strobes at once.

// File: rtl/lp_track.sv
module lp_track #(
  parameter int  LBL_W     = 20,
  parameter int  REG_W     = 5,
  parameter bit  HAS_EXT   = 1'b1,
  parameter bit  HAS_SMODE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cur_priv,
  input  logic [1:0]       ret_priv,
  input  logic             cfg_m_sec_en,
  input  logic             cfg_m_env_en,
  input  logic             cfg_s_env_en,
  input  logic             ev_jump,
  input  logic [REG_W-1:0] jump_src,
  input  logic             ev_pad,
  input  logic [LBL_W-1:0] pad_label,
  input  logic [LBL_W-1:0] x7_hi,
  input  logic             ev_trap,
  input  logic [1:0]       trap_priv,
  input  logic             ev_mret,
  input  logic             ev_sret,
  output logic             lp_expect,
  output logic             lp_prev_m,
  output logic             lp_prev_s,
  output logic             lp_fault
);
  localparam logic [1:0] PRIV_M = 2'b11;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [REG_W-1:0] RA_REG  = REG_W'(1);
  localparam logic [REG_W-1:0] ALT_RA  = REG_W'(5);
  localparam logic [REG_W-1:0] GUARDED = REG_W'(7);

  function automatic logic en_for(input logic [1:0] p);
    if (!HAS_EXT)          return 1'b0;
    else if (p == PRIV_M)  return cfg_m_sec_en;
    else if (p == PRIV_S)  return cfg_m_env_en;
    else if (HAS_SMODE)    return cfg_s_env_en;
    else                   return cfg_m_env_en;
  endfunction

  logic en_cur, en_ret, src_qual, pad_live, pad_bad, any_ret;
  logic exp_d, pm_d, ps_d, fault_d;

  assign en_cur   = en_for(cur_priv);
  assign en_ret   = en_for(ret_priv);
  assign src_qual = (jump_src != RA_REG) && (jump_src != ALT_RA) && (jump_src != GUARDED);
  assign pad_live = en_cur && lp_expect;
  assign pad_bad  = pad_live && (pad_label != '0) && (pad_label != x7_hi);
  assign any_ret  = ev_mret || ev_sret;

  always_comb begin
    exp_d   = lp_expect;
    pm_d    = lp_prev_m;
    ps_d    = lp_prev_s;
    fault_d = 1'b0;
    if (ev_trap) begin
      if (trap_priv == PRIV_M) pm_d = lp_expect;
      else                     ps_d = lp_expect;
      exp_d = 1'b0;
    end else if (ev_mret) begin
      exp_d = en_ret ? lp_prev_m : 1'b0;
      pm_d  = 1'b0;
    end else if (ev_sret) begin
      exp_d = en_ret ? lp_prev_s : 1'b0;
      ps_d  = 1'b0;
    end else if (ev_pad) begin
      if (pad_bad)       fault_d = 1'b1;
      else if (pad_live) exp_d   = 1'b0;
    end else if (ev_jump && en_cur && src_qual) begin
      exp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_expect <= 1'b0;
      lp_prev_m <= 1'b0;
      lp_prev_s <= 1'b0;
      lp_fault  <= 1'b0;
    end else begin
      lp_expect <= exp_d;
      lp_prev_m <= pm_d;
      lp_prev_s <= ps_d;
      lp_fault  <= fault_d;
    end
  end

  a_r7_trap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap |=> !lp_expect);

  a_r4_fault_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    lp_fault |-> (lp_expect && $past(lp_expect)));

  a_r8_mret_clears_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mret && !ev_trap) |=> !lp_prev_m);

  a_r9_sret_clears_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sret && !ev_trap && !ev_mret) |=> !lp_prev_s);

  a_r3_link_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_jump && !ev_trap && !any_ret && !ev_pad && !lp_expect && !src_qual) |=> !lp_expect);

  a_r10_trap_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap |=> !lp_fault);

  a_r6_idle_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pad && !ev_trap && !any_ret && !pad_live) |=> (!lp_fault && $stable(lp_expect)));
endmodule

// File: tb/lp_track_tb.sv
module lp_track_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cur_priv = 2'b11, ret_priv = 2'b11, trap_priv = 2'b11;
  logic cfg_m_sec_en = 0, cfg_m_env_en = 0, cfg_s_env_en = 0;
  logic ev_jump = 0, ev_pad = 0, ev_trap = 0, ev_mret = 0, ev_sret = 0;
  logic [4:0] jump_src = 0;
  logic [19:0] pad_label = 0, x7_hi = 0;
  logic lp_expect, lp_prev_m, lp_prev_s, lp_fault;

  int checks = 0, failures = 0;
  bit m_exp = 0, m_pm = 0, m_ps = 0, m_flt = 0;

  always #10 clk = ~clk;

  lp_track dut_i (.clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .ret_priv(ret_priv),
    .cfg_m_sec_en(cfg_m_sec_en), .cfg_m_env_en(cfg_m_env_en), .cfg_s_env_en(cfg_s_env_en),
    .ev_jump(ev_jump), .jump_src(jump_src), .ev_pad(ev_pad), .pad_label(pad_label),
    .x7_hi(x7_hi), .ev_trap(ev_trap), .trap_priv(trap_priv), .ev_mret(ev_mret),
    .ev_sret(ev_sret), .lp_expect(lp_expect), .lp_prev_m(lp_prev_m),
    .lp_prev_s(lp_prev_s), .lp_fault(lp_fault));

  function automatic bit ref_en(input logic [1:0] p);
    if (p == 2'b11) return cfg_m_sec_en;
    if (p == 2'b01) return cfg_m_env_en;
    return cfg_s_env_en;
  endfunction

  task automatic chk(input string tag, input string nm, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%0b exp=%0b", tag, nm, got, exp);
    end
  endtask

  task automatic step(input string tag);
    bit ne = m_exp, npm = m_pm, nps = m_ps, nf = 0;
    bool_blk: begin
      if (ev_trap) begin
        if (trap_priv == 2'b11) npm = m_exp; else nps = m_exp;
        ne = 0;
      end else if (ev_mret) begin
        ne = ref_en(ret_priv) ? m_pm : 1'b0; npm = 0;
      end else if (ev_sret) begin
        ne = ref_en(ret_priv) ? m_ps : 1'b0; nps = 0;
      end else if (ev_pad) begin
        if (ref_en(cur_priv) && m_exp) begin
          if (pad_label != 0 && pad_label != x7_hi) nf = 1; else ne = 0;
        end
      end else if (ev_jump) begin
        if (ref_en(cur_priv) && jump_src != 1 && jump_src != 5 && jump_src != 7) ne = 1;
      end
    end
    @(posedge clk);
    m_exp = ne; m_pm = npm; m_ps = nps; m_flt = nf;
    @(negedge clk);
    chk(tag, "lp_expect", lp_expect, m_exp);
    chk(tag, "lp_prev_m", lp_prev_m, m_pm);
    chk(tag, "lp_prev_s", lp_prev_s, m_ps);
    chk(tag, "lp_fault", lp_fault, m_flt);
    ev_jump = 0; ev_pad = 0; ev_trap = 0; ev_mret = 0; ev_sret = 0;
  endtask

  task automatic jmp(input logic [4:0] r, input string tag);
    ev_jump = 1; jump_src = r; step(tag);
  endtask
  task automatic pad(input logic [19:0] l, input string tag);
    ev_pad = 1; pad_label = l; step(tag);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk("R1", "lp_expect", lp_expect, 0);
    chk("R1", "lp_prev_m", lp_prev_m, 0);
    chk("R1", "lp_prev_s", lp_prev_s, 0);
    chk("R1", "lp_fault", lp_fault, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "lp_expect", lp_expect, 0);

    cur_priv = 2'b11; cfg_m_sec_en = 1; x7_hi = 20'hABCDE;
    jmp(5'd1, "R3"); jmp(5'd5, "R3"); jmp(5'd7, "R3");
    jmp(5'd6, "R3");
    pad(20'h0, "R5");
    pad(20'h12345, "R6");
    jmp(5'd10, "R3");
    pad(20'h12345, "R4");
    step("R4");
    pad(20'hABCDE, "R5");
    jmp(5'd12, "R3");
    cur_priv = 2'b01; cfg_m_env_en = 0;
    pad(20'h11111, "R6");
    cur_priv = 2'b11;
    ev_trap = 1; trap_priv = 2'b11; step("R7");
    ev_mret = 1; ret_priv = 2'b11; step("R8");
    ev_trap = 1; trap_priv = 2'b01; step("R7");
    jmp(5'd9, "R3");
    ev_trap = 1; trap_priv = 2'b00; step("R7");
    cfg_s_env_en = 0; ev_sret = 1; ret_priv = 2'b00; step("R9");
    cur_priv = 2'b01; cfg_m_env_en = 0; jmp(5'd9, "R2");
    cfg_m_env_en = 1; jmp(5'd9, "R2");
    cur_priv = 2'b00; cfg_m_env_en = 1; cfg_s_env_en = 0;
    ev_trap = 1; trap_priv = 2'b11; step("R7");
    jmp(5'd9, "R2");
    cfg_s_env_en = 1; jmp(5'd9, "R2");
    cur_priv = 2'b11; cfg_m_sec_en = 0; jmp(5'd9, "R2");
    cfg_m_sec_en = 1;
    ev_trap = 1; ev_jump = 1; jump_src = 5'd9; trap_priv = 2'b01; step("R10");
    ev_trap = 1; ev_pad = 1; pad_label = 20'h1; step("R10");
    ev_mret = 1; ev_jump = 1; ret_priv = 2'b11; step("R10");
    ev_sret = 1; ev_pad = 1; ret_priv = 2'b01; step("R10");
    jmp(5'd9, "R3");
    ev_pad = 1; ev_jump = 1; pad_label = 20'h7; step("R10");

    for (int i = 0; i < 4000; i++) begin
      int sel;
      cur_priv  = 2'($urandom_range(0, 3));
      ret_priv  = 2'($urandom_range(0, 3));
      trap_priv = 2'($urandom_range(0, 3));
      cfg_m_sec_en = ($urandom_range(0, 3) != 0);
      cfg_m_env_en = ($urandom_range(0, 3) != 0);
      cfg_s_env_en = ($urandom_range(0, 3) != 0);
      x7_hi = ($urandom_range(0, 1) == 0) ? 20'h00F0F : 20'($urandom);
      sel = $urandom_range(0, 2);
      pad_label = (sel == 0) ? 20'h0 : (sel == 1) ? x7_hi : 20'($urandom);
      sel = $urandom_range(0, 3);
      jump_src = (sel == 0) ? 5'd1 : (sel == 1) ? 5'd5 : (sel == 2) ? 5'd7 : 5'($urandom);
      ev_jump = ($urandom_range(0, 2) == 0);
      ev_pad  = ($urandom_range(0, 2) == 0);
      ev_trap = ($urandom_range(0, 9) == 0);
      ev_mret = ($urandom_range(0, 11) == 0);
      ev_sret = ($urandom_range(0, 11) == 0);
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule